// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Back Data Cache

This block is a 16 KB data cache for a 32-bit byte-addressed processor. The cache has four ways. Each block holds one 32-bit word, so there are 1024 sets. The processor side issues a read or a write with an address, write data and byte enables. When the word is resident, the access completes in the same cycle: the read data is returned and the hit flag is raised. When the word is not resident, the stall output rises. The requester must then hold its request until the stall clears.

A miss first chooses a victim way. The lowest-numbered invalid way is preferred; when the set is full, the least recently used way is taken. A dirty victim is first written to the lower-level memory, and the new word is then read in. The lower-level port moves one word per request under a valid/ready handshake. Writes use a write-back, write-allocate policy, and each line tracks its own dirty state. Recency is kept as a 2-bit age per way in each set.

Top module: `dcache_4way`

## Requirements
- R1: The address splits into a 20-bit tag in bits [31:12], a 10-bit set index in bits [11:2] and a byte offset in bits [1:0]. Up to four words with the same index and different tags are resident at the same time.
- R2: A request to a resident word raises `cpu_hit`, keeps `cpu_stall` low and returns the stored word on `cpu_rdata`, all in the cycle the request is presented.
- R3: A request to a word that is not resident keeps `cpu_hit` low and raises `cpu_stall` in that cycle. The stall holds until the block has arrived from the lower level. The held request then completes as a hit in the following cycle.
- R4: While a set has an invalid way, a miss fills the lowest-numbered invalid way and evicts nothing. After reset, four distinct tags in one set all stay resident.
- R5: When all four ways of a set are valid, a miss replaces the least recently used way. Both hits and fills count as uses. After reset the ages in every set are 0,1,2,3 for ways 0 to 3.
- R6: A write hit replaces byte i of the stored word (bits 8i+7:8i) with the write data wherever `cpu_be[i]` is 1, keeps the other bytes, and marks the line dirty.
- R7: A write miss first fetches the block and then merges the write into it as in R6, leaving the line dirty.
- R8: A dirty victim is written to the lower level before the read is issued. The write uses address {stored tag, index, 2'b00} and the stored word. A clean victim causes no write.
- R9: Reset invalidates every line and discards dirty data without writing it back. With no request pending, `cpu_stall`, `cpu_hit` and `mem_valid` are low.
- R10: A lower-level request keeps `mem_valid`, `mem_we` and `mem_addr` steady until `mem_ready` is seen. A write-back (`mem_we`=1) is followed directly by the fill read (`mem_we`=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held while stalled |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_rdata | output | 32 | Word read from the hitting way |
| cpu_hit | output | 1 | Access hit this cycle |
| cpu_stall | output | 1 | Access not complete, hold the request |
| mem_valid | output | 1 | Lower-level request valid |
| mem_we | output | 1 | 1 for write-back, 0 for fill read |
| mem_addr | output | 32 | Word-aligned lower-level address |
| mem_wdata | output | 32 | Write-back data |
| mem_ready | input | 1 | Lower level accepts the request; read data valid |
| mem_rdata | input | 32 | Fill data |

## Verification
A write hit updates three things in the same clock edge: the merged data, the dirty bit and the age of the whole set. An error in any one of them stays hidden until a later eviction. The bench provokes this with a partial-byte write to a line that is not the oldest, then misses in that set until the line becomes the victim. The check is that the write-back carries exactly the merged word, at the rebuilt address, and only at the miss that the recency order predicts.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    parameter int ADDR_W = 32;
    parameter int WORD_W = 32;
    parameter int WAYS   = 4;
    parameter int SETS   = 1024;

    localparam int BE_W  = WORD_W / 8;
    localparam int OFF_W = $clog2(BE_W);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [WAY_W-1:0]             way_t;
    typedef logic [IDX_W-1:0]             idx_t;
    typedef logic [TAG_W-1:0]             tag_t;
    typedef logic [WORD_W-1:0]            word_t;
    typedef logic [WAYS-1:0][WAY_W-1:0]   ages_t;

    typedef enum logic [1:0] {S_LOOK, S_EVICT, S_FILL} st_e;

    // latched miss context
    typedef struct packed {
        st_e  st;
        way_t way;
        idx_t idx;
        tag_t tag;
        tag_t old_tag;
    } ctl_t;

    // array write requests produced by the combinational process
    typedef struct packed {
        logic  line_we;
        way_t  way;
        idx_t  idx;
        tag_t  tag;
        word_t data;
        logic  dirty;
        logic  age_we;
        idx_t  age_idx;
        ages_t ages;
    } upd_t;
endpackage

// File: rtl/dcache_lookup.sv
module dcache_lookup
    import dcache_pkg::*;
(
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  tag_t                       tag_i,
    output logic                       hit_o,
    output way_t                       way_o
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
    end

    always_comb begin
        hit_o = |match;
        way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) way_o = way_t'(w);
        end
    end
endmodule

// File: rtl/dcache_victim.sv
module dcache_victim
    import dcache_pkg::*;
(
    input  logic [WAYS-1:0] valid_i,
    input  ages_t           ages_i,
    output way_t            way_o
);
    logic found;

    always_comb begin
        way_o = '0;
        found = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                way_o = way_t'(w);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (ages_i[w] == way_t'(WAYS - 1)) way_o = way_t'(w);
            end
        end
    end
endmodule

// File: rtl/dcache_age.sv
module dcache_age
    import dcache_pkg::*;
(
    input  ages_t ages_i,
    input  way_t  acc_i,
    output ages_t ages_o
);
    for (genvar g = 0; g < WAYS; g++) begin : g_age
        assign ages_o[g] = (way_t'(g) == acc_i)           ? '0 :
                           (ages_i[g] < ages_i[acc_i])    ? ages_i[g] + 1'b1 :
                                                            ages_i[g];
    end
endmodule

// File: rtl/dcache_4way.sv
module dcache_4way
    import dcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_stall,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata
);
    logic [WAYS-1:0] valid_q [SETS];
    logic [WAYS-1:0] dirty_q [SETS];
    ages_t           age_q   [SETS];
    tag_t            tag_q   [WAYS][SETS];
    word_t           data_q  [WAYS][SETS];

    ctl_t ctl_q, ctl_d;
    upd_t upd;

    idx_t idx;
    tag_t req_tag;
    logic unused_off;
    assign idx        = cpu_addr[OFF_W +: IDX_W];
    assign req_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
    assign unused_off = ^cpu_addr[OFF_W-1:0];

    logic [WAYS-1:0]            set_valid, set_dirty;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_valid[w] = valid_q[idx][w];
            set_dirty[w] = dirty_q[idx][w];
            set_tags[w]  = tag_q[w][idx];
        end
    end

    logic hit;
    way_t hit_way, victim;
    dcache_lookup u_lookup (.valid_i(set_valid), .tags_i(set_tags), .tag_i(req_tag),
                            .hit_o(hit), .way_o(hit_way));
    dcache_victim u_victim (.valid_i(set_valid), .ages_i(age_q[idx]), .way_o(victim));

    logic  filling;
    ages_t age_src, age_new;
    way_t  age_way;
    assign filling = (ctl_q.st == S_FILL);
    assign age_src = filling ? age_q[ctl_q.idx] : age_q[idx];
    assign age_way = filling ? ctl_q.way : hit_way;
    dcache_age u_age (.ages_i(age_src), .acc_i(age_way), .ages_o(age_new));

    word_t hit_word, merged;
    assign hit_word  = data_q[hit_way][idx];
    assign cpu_rdata = hit_word;
    for (genvar b = 0; b < BE_W; b++) begin : g_merge
        assign merged[8*b +: 8] = cpu_be[b] ? cpu_wdata[8*b +: 8] : hit_word[8*b +: 8];
    end

    always_comb begin
        ctl_d     = ctl_q;
        upd       = '0;
        cpu_hit   = 1'b0;
        cpu_stall = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (ctl_q.st)
            S_LOOK: begin
                if (cpu_req) begin
                    if (hit) begin
                        cpu_hit     = 1'b1;
                        upd.age_we  = 1'b1;
                        upd.age_idx = idx;
                        upd.ages    = age_new;
                        if (cpu_we) begin
                            upd.line_we = 1'b1;
                            upd.way     = hit_way;
                            upd.idx     = idx;
                            upd.tag     = req_tag;
                            upd.data    = merged;
                            upd.dirty   = 1'b1;
                        end
                    end else begin
                        cpu_stall     = 1'b1;
                        ctl_d.way     = victim;
                        ctl_d.idx     = idx;
                        ctl_d.tag     = req_tag;
                        ctl_d.old_tag = set_tags[victim];
                        ctl_d.st      = (set_valid[victim] && set_dirty[victim]) ? S_EVICT : S_FILL;
                    end
                end
            end
            S_EVICT: begin
                cpu_stall = 1'b1;
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {ctl_q.old_tag, ctl_q.idx, {OFF_W{1'b0}}};
                mem_wdata = data_q[ctl_q.way][ctl_q.idx];
                if (mem_ready) ctl_d.st = S_FILL;
            end
            S_FILL: begin
                cpu_stall = 1'b1;
                mem_valid = 1'b1;
                mem_addr  = {ctl_q.tag, ctl_q.idx, {OFF_W{1'b0}}};
                if (mem_ready) begin
                    upd.line_we = 1'b1;
                    upd.way     = ctl_q.way;
                    upd.idx     = ctl_q.idx;
                    upd.tag     = ctl_q.tag;
                    upd.data    = mem_rdata;
                    upd.dirty   = 1'b0;
                    upd.age_we  = 1'b1;
                    upd.age_idx = ctl_q.idx;
                    upd.ages    = age_new;
                    ctl_d.st    = S_LOOK;
                end
            end
            default: ctl_d.st = S_LOOK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_LOOK, default: '0};
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= way_t'(w);
            end
        end else begin
            ctl_q <= ctl_d;
            if (upd.line_we) begin
                valid_q[upd.idx][upd.way] <= 1'b1;
                dirty_q[upd.idx][upd.way] <= upd.dirty;
            end
            if (upd.age_we) age_q[upd.age_idx] <= upd.ages;
        end
    end

    always_ff @(posedge clk) begin
        if (upd.line_we) begin
            data_q[upd.way][upd.idx] <= upd.data;
            tag_q[upd.way][upd.idx]  <= upd.tag;
        end
    end
endmodule

// File: rtl/dcache_chk.sv
module dcache_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req,
    input logic        cpu_hit,
    input logic        cpu_stall,
    input logic        mem_valid,
    input logic        mem_we,
    input logic        mem_ready,
    input logic [31:0] mem_addr
);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

    p_evict_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we && mem_ready |=> mem_valid && !mem_we);

    p_fill_then_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_we && mem_ready && cpu_req |=> cpu_hit && !cpu_stall);

    p_miss_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_hit |-> cpu_stall);
endmodule

bind dcache_4way dcache_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_hit(cpu_hit),
    .cpu_stall(cpu_stall), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_ready(mem_ready), .mem_addr(mem_addr)
);

// File: tb/tb_dcache_4way.sv
module tb_dcache_4way;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_hit, cpu_stall;
    logic        mem_valid, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcache_4way dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // lower-level model: ready after a short latency, unwritten words read addr ^ A5A50000
    logic [31:0] bmem [logic [31:0]];
    int          lat = 0;
    int          wb_cnt = 0;
    logic [31:0] last_wa = '0, last_wd = '0;

    always @(posedge clk) begin
        mem_ready <= 1'b0;
        if (mem_valid && !mem_ready) begin
            if (lat == 2) begin
                lat       <= 0;
                mem_ready <= 1'b1;
                if (mem_we) begin
                    bmem[mem_addr] = mem_wdata;
                    wb_cnt  <= wb_cnt + 1;
                    last_wa <= mem_addr;
                    last_wd <= mem_wdata;
                end else begin
                    mem_rdata <= bmem.exists(mem_addr) ? bmem[mem_addr] : (mem_addr ^ 32'hA5A5_0000);
                end
            end else begin
                lat <= lat + 1;
            end
        end
    end

    int   n_cmp = 0, n_bad = 0;
    logic wd_expired = 1'b0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          input logic [3:0] be, output logic h, output int ns, output logic [31:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        #1;
        h  = cpu_hit;
        ns = 0;
        while (cpu_stall && !wd_expired) begin
            @(negedge clk);
            #1;
            ns++;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic        hit;
        logic        chk_rd;
        logic [31:0] rd;
        logic [3:0]  wb;
        logic [31:0] wa;
        logic [31:0] wd;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VT [NV] = '{
        // block sequence 0,8,0,6,8 (R1 index bits [11:2])
        '{1'b0, 32'h0000_0000, 32'h0, 4'h0, 1'b0, 1'b1, 32'hA5A5_0000, 4'd0, 32'h0, 32'h0},
        '{1'b0, 32'h0000_0020, 32'h0, 4'h0, 1'b0, 1'b1, 32'hA5A5_0020, 4'd0, 32'h0, 32'h0},
        '{1'b0, 32'h0000_0000, 32'h0, 4'h0, 1'b1, 1'b1, 32'hA5A5_0000, 4'd0, 32'h0, 32'h0},
        '{1'b0, 32'h0000_0018, 32'h0, 4'h0, 1'b0, 1'b1, 32'hA5A5_0018, 4'd0, 32'h0, 32'h0},
        '{1'b0, 32'h0000_0020, 32'h0, 4'h0, 1'b1, 1'b1, 32'hA5A5_0020, 4'd0, 32'h0, 32'h0},
        // set 1: R7 write miss, then R4 four tags resident
        '{1'b1, 32'h0000_0004, 32'h1111_1111, 4'hF, 1'b0, 1'b0, 32'h0, 4'd0, 32'h0, 32'h0},
        '{1'b0, 32'h0000_0004, 32'h0, 4'h0, 1'b1, 1'b1, 32'h1111_1111, 4'd0, 32'h0, 32'h0},
        '{1'b0, 32'h0000_1004, 32'h0, 4'h0, 1'b0, 1'b1, 32'hA5A5_1004, 4'd0, 32'h0, 32'h0},
        '{1'b0, 32'h0000_2004, 32'h0, 4'h0, 1'b0, 1'b1, 32'hA5A5_2004, 4'd0, 32'h0, 32'h0},
        '{1'b0, 32'h0000_3004, 32'h0, 4'h0, 1'b0, 1'b1, 32'hA5A5_3004, 4'd0, 32'h0, 32'h0},
        '{1'b0, 32'h0000_0004, 32'h0, 4'h0, 1'b1, 1'b1, 32'h1111_1111, 4'd0, 32'h0, 32'h0},
        // R6 partial write hit
        '{1'b1, 32'h0000_3004, 32'h0000_0077, 4'h1, 1'b1, 1'b0, 32'h0, 4'd0, 32'h0, 32'h0},
        '{1'b0, 32'h0000_3004, 32'h0, 4'h0, 1'b1, 1'b1, 32'hA5A5_3077, 4'd0, 32'h0, 32'h0},
        // R5 LRU victims: tag1 (clean), tag2 (clean), tag0 (dirty), tag3 (dirty), tag4 (clean)
        '{1'b0, 32'h0000_4004, 32'h0, 4'h0, 1'b0, 1'b1, 32'hA5A5_4004, 4'd0, 32'h0, 32'h0},
        '{1'b0, 32'h0000_1004, 32'h0, 4'h0, 1'b0, 1'b1, 32'hA5A5_1004, 4'd0, 32'h0, 32'h0},
        '{1'b0, 32'h0000_2004, 32'h0, 4'h0, 1'b0, 1'b1, 32'hA5A5_2004, 4'd1, 32'h0000_0004, 32'h1111_1111},
        '{1'b0, 32'h0000_0004, 32'h0, 4'h0, 1'b0, 1'b1, 32'h1111_1111, 4'd2, 32'h0000_3004, 32'hA5A5_3077},
        '{1'b0, 32'h0000_1004, 32'h0, 4'h0, 1'b1, 1'b1, 32'hA5A5_1004, 4'd2, 32'h0, 32'h0},
        '{1'b0, 32'h0000_3004, 32'h0, 4'h0, 1'b0, 1'b1, 32'hA5A5_3077, 4'd2, 32'h0, 32'h0},
        // R7 write miss with upper-half byte enables
        '{1'b1, 32'h8000_0008, 32'hAABB_0000, 4'hC, 1'b0, 1'b0, 32'h0, 4'd2, 32'h0, 32'h0},
        '{1'b0, 32'h8000_0008, 32'h0, 4'h0, 1'b1, 1'b1, 32'hAABB_0008, 4'd2, 32'h0, 32'h0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        wd_expired = 1'b1;
        n_cmp++;
        n_bad++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic        h;
        int          ns;
        logic [31:0] rd;
        int          prev_wb;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 idle state after reset
        chk(!cpu_stall, "R9 stall after reset", 32'(cpu_stall), 32'd0);
        chk(!cpu_hit,   "R9 hit after reset",   32'(cpu_hit),   32'd0);
        chk(!mem_valid, "R9 mem_valid after reset", 32'(mem_valid), 32'd0);

        prev_wb = 0;
        for (int i = 0; i < NV; i++) begin
            access(VT[i].we, VT[i].addr, VT[i].wdata, VT[i].be, h, ns, rd);
            if (VT[i].hit) begin
                chk(h == 1'b1, "R2 hit flag", 32'(h), 32'd1);
                chk(ns == 0,   "R2 no stall on hit", 32'(ns), 32'd0);
            end else begin
                chk(h == 1'b0, "R3 miss flag", 32'(h), 32'd0);
                chk(ns > 0,    "R3 stall on miss", 32'(ns), 32'd1);
            end
            if (VT[i].chk_rd) chk(rd == VT[i].rd, "R2 read data", rd, VT[i].rd);
            chk(wb_cnt == int'(VT[i].wb), "R8 write-back count", 32'(wb_cnt), 32'(VT[i].wb));
            if (int'(VT[i].wb) != prev_wb) begin
                chk(last_wa == VT[i].wa, "R8 victim address", last_wa, VT[i].wa);
                chk(last_wd == VT[i].wd, "R8 victim data",    last_wd, VT[i].wd);
            end
            prev_wb = int'(VT[i].wb);
        end

        // R9: reset mid-run drops the dirty line at 0x80000008 without a write-back
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        access(1'b0, 32'h0000_0000, 32'h0, 4'h0, h, ns, rd);
        chk(h == 1'b0, "R9 line invalid after reset", 32'(h), 32'd0);
        access(1'b0, 32'h8000_0008, 32'h0, 4'h0, h, ns, rd);
        chk(h == 1'b0, "R9 dirty line dropped", 32'(h), 32'd0);
        chk(rd == 32'h25A5_0008, "R9 refetched word", rd, 32'h25A5_0008);
        chk(wb_cnt == 2, "R9 no write-back after reset", 32'(wb_cnt), 32'd2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule